// File: doc/BRIEF.md
# Streaming Write Allocation Mode Tracker

This block sits beside a cache's write path and watches every write that arrives: its byte address, its size in bytes and the cache line it falls in. It decides whether the writes form one contiguous stream. While a contiguous stream grows, it moves the cache from allocating lines on write, to merging writes, and finally to not allocating at all. Two byte-count thresholds mark the steps. Any break in contiguity brings the policy back to allocating.

Next to the policy state it keeps a small table of per-line hold counters. A contiguous write arms the counter of its line. The cache then queries that counter to learn whether a write to the line should be held back briefly, so that the following contiguous data can merge with it. Each query of an armed counter uses up one cycle of the hold.

Top module: `wr_stream_mode`

## Requirements
- R1: After reset, and in the cycle after a `clear` pulse, `mode` is 0 (allocate), `allocate` is 1 and `coalesce` is 0. `clear` also discards the stream state: the next write counts as non-contiguous and its size becomes the whole byte count.
- R2: A write counts as contiguous only when its address equals the previous write's address plus the previous write's size. Any other address counts as non-contiguous.
- R3: On a contiguous write in mode 0, the size is added to the byte count. If the new count is strictly greater than `COAL_LIM`, `mode` becomes 1 (coalesce) in the next cycle. A count equal to the limit leaves the mode at 0.
- R4: On a contiguous write in mode 1, the size is added to the byte count. If the new count is strictly greater than `NOALLOC_LIM`, `mode` becomes 2 (no-allocate) in the next cycle.
- R5: Mode 2 is held for as long as writes stay contiguous. A non-contiguous write in any mode sets `mode` to 0 and sets the byte count to that write's size.
- R6: `mode` is encoded as 0 = allocate, 1 = coalesce, 2 = no-allocate, and never takes the value 3. `allocate` is 1 exactly when `mode` is not 2. `coalesce` is 1 exactly when `mode` is 2.
- R7: A contiguous write loads the hold counter of its line with `DLY_THR`. After that, `dly_needed` is 1 for exactly `DLY_THR` queries of that line. Each query that sees a nonzero counter lowers it by one.
- R8: A non-contiguous write clears the hold counter of its line, so the next query of that line gives `dly_needed` = 0.
- R9: The hold table has `DEPTH` (8) entries, selected by the low 3 bits of the line address. Lines that differ only above those bits share an entry. Lines that differ in those bits do not affect one another.
- R10: The byte count saturates at 2^`CW`-1 and does not wrap. With `CW`=6, `COAL_LIM`=20 and `NOALLOC_LIM`=40, three contiguous writes of 30 bytes reach mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous discard of all stream and hold state |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | AW | Byte address of the write |
| wr_size | input | SW | Size of the write in bytes |
| wr_line | input | LW | Line address of the write |
| query_valid | input | 1 | Hold query this cycle |
| query_line | input | LW | Line address being queried |
| mode | output | 2 | Policy mode: 0 allocate, 1 coalesce, 2 no-allocate |
| allocate | output | 1 | Allocation on write is permitted |
| coalesce | output | 1 | Writes should be merged |
| dly_needed | output | 1 | The queried line's hold counter is nonzero (combinational) |

## Verification
`mode`, `allocate` and `coalesce` come from a register. They change one cycle after the edge that accepts a write or a clear. The bench therefore drives each write for one cycle starting on a falling edge and reads these outputs on the next falling edge. `dly_needed` follows the queried line's counter combinationally, so the bench reads it 1 ns after it applies a query, before the rising edge that lowers the counter. A counter armed by a write is first seen by a query in the cycle after that write.

// File: rtl/wr_stream_mode.sv
module wr_stream_mode #(
  parameter int unsigned AW          = 32,
  parameter int unsigned SW          = 8,
  parameter int unsigned LW          = 26,
  parameter int unsigned CW          = 16,
  parameter int unsigned COAL_LIM    = 128,
  parameter int unsigned NOALLOC_LIM = 512,
  parameter int unsigned DLY_THR     = 4,
  parameter int unsigned DEPTH       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [SW-1:0] wr_size,
  input  logic [LW-1:0] wr_line,
  input  logic          query_valid,
  input  logic [LW-1:0] query_line,
  output logic [1:0]    mode,
  output logic          allocate,
  output logic          coalesce,
  output logic          dly_needed
);
  localparam int unsigned IW   = $clog2(DEPTH);
  localparam int unsigned DCW  = $clog2(DLY_THR + 1);
  localparam int unsigned SUMW = ((CW > SW) ? CW : SW) + 1;
  localparam logic [1:0] M_ALLOC   = 2'd0;
  localparam logic [1:0] M_COAL    = 2'd1;
  localparam logic [1:0] M_NOALLOC = 2'd2;
  localparam logic [CW-1:0]  CNT_MAX = {CW{1'b1}};
  localparam logic [DCW-1:0] THR     = DCW'(DLY_THR);

  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] next_q;
  logic          have_next_q;
  logic [DCW-1:0] ctr_q [DEPTH];

  logic [IW-1:0]   widx, qidx;
  logic            seq;
  logic [SUMW-1:0] sum, size_ext;
  logic [CW-1:0]   cnt_add, size_sat;

  assign widx     = wr_line[IW-1:0];
  assign qidx     = query_line[IW-1:0];
  assign seq      = have_next_q && (wr_addr == next_q);
  assign size_ext = SUMW'(wr_size);
  assign sum      = SUMW'(cnt_q) + size_ext;
  assign cnt_add  = (sum > SUMW'(CNT_MAX)) ? CNT_MAX : sum[CW-1:0];
  assign size_sat = (size_ext > SUMW'(CNT_MAX)) ? CNT_MAX : size_ext[CW-1:0];

  assign mode       = mode_q;
  assign allocate   = (mode_q != M_NOALLOC);
  assign coalesce   = (mode_q == M_NOALLOC);
  assign dly_needed = query_valid && (ctr_q[qidx] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_ALLOC;
      cnt_q       <= '0;
      next_q      <= '0;
      have_next_q <= 1'b0;
    end else if (clear) begin
      mode_q      <= M_ALLOC;
      cnt_q       <= '0;
      have_next_q <= 1'b0;
    end else if (wr_valid) begin
      next_q      <= wr_addr + AW'(wr_size);
      have_next_q <= 1'b1;
      if (!seq) begin
        cnt_q  <= size_sat;
        mode_q <= M_ALLOC;
      end else if (mode_q != M_NOALLOC) begin
        cnt_q <= cnt_add;
        if (mode_q == M_ALLOC && 32'(cnt_add) > COAL_LIM)
          mode_q <= M_COAL;
        else if (mode_q == M_COAL && 32'(cnt_add) > NOALLOC_LIM)
          mode_q <= M_NOALLOC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) ctr_q[i] <= '0;
    end else if (clear) begin
      for (int i = 0; i < int'(DEPTH); i++) ctr_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (wr_valid && widx == IW'(i))
          ctr_q[i] <= seq ? THR : '0;
        else if (query_valid && qidx == IW'(i) && ctr_q[i] != '0)
          ctr_q[i] <= ctr_q[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_stream_mode_chk.sv
module wr_stream_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic       wr_valid,
  input logic       query_valid,
  input logic [1:0] mode,
  input logic       allocate,
  input logic       coalesce,
  input logic       dly_needed
);
  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3);
  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) allocate != coalesce);
  // R1
  clear_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n) clear |=> mode == 2'd0);
  // R3
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n) mode == 2'd0 |=> mode != 2'd2);
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (!wr_valid && !clear) |=> $stable(mode));
  // R5
  noalloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_valid && !clear) |=> coalesce);
  // R7
  dly_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !query_valid |-> !dly_needed);
endmodule

bind wr_stream_mode wr_stream_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .wr_valid(wr_valid),
  .query_valid(query_valid), .mode(mode), .allocate(allocate),
  .coalesce(coalesce), .dly_needed(dly_needed)
);

// File: tb/tb_wr_stream_mode.sv
`timescale 1ns/1ps
module tb_wr_stream_mode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [7:0]  wr_size = '0;
  logic [25:0] wr_line = '0;
  logic        query_valid = 1'b0;
  logic [25:0] query_line = '0;
  logic [1:0]  mode, mode_s;
  logic        allocate, coalesce, dly_needed;
  logic        allocate_s, coalesce_s, dly_needed_s;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wr_stream_mode dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_line(wr_line),
    .query_valid(query_valid), .query_line(query_line),
    .mode(mode), .allocate(allocate), .coalesce(coalesce), .dly_needed(dly_needed)
  );

  wr_stream_mode #(.CW(6), .COAL_LIM(20), .NOALLOC_LIM(40)) dut_sat (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_line(wr_line),
    .query_valid(query_valid), .query_line(query_line),
    .mode(mode_s), .allocate(allocate_s), .coalesce(coalesce_s), .dly_needed(dly_needed_s)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_mode(input string req, input int exp);
    check(req, mode, exp);
    check(req, allocate, (exp != 2) ? 1 : 0);
    check(req, coalesce, (exp == 2) ? 1 : 0);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [7:0] s, input logic [25:0] l);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_size = s; wr_line = l;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic do_query(input logic [25:0] l, output logic r);
    @(negedge clk);
    query_valid = 1'b1; query_line = l;
    #1 r = dly_needed;
    @(negedge clk);
    query_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic r;
    check_mode("R1 reset", 0);
    check("R6 sat-reset mode", mode_s, 0);
    do_query(26'd0, r);
    check("R7 reset hold", r, 0);
  endtask

  task automatic t_ramp();
    do_clear();
    check_mode("R1 clear", 0);
    for (int i = 0; i < 10; i++) begin
      do_write(32'h1000 + 32'(i) * 64, 8'd64, 26'h40 + 26'(i));
      if (i < 2)      check_mode("R3 below limit", 0);
      else if (i < 8) check_mode("R3 R4 coalesce", 1);
      else            check_mode("R4 R5 no-allocate", 2);
    end
  endtask

  task automatic t_break();
    do_write(32'h9000, 8'd200, 26'h240);
    check_mode("R5 break to allocate", 0);
    do_write(32'h90C8, 8'd1, 26'h243);
    check_mode("R5 count equals size", 1);
  endtask

  task automatic t_gap();
    do_clear();
    do_write(32'h0, 8'd64, 26'd0);
    do_write(32'h50, 8'd64, 26'd1);
    do_write(32'h90, 8'd64, 26'd2);
    check_mode("R2 gap restarts count", 0);
    do_write(32'hD0, 8'd64, 26'd3);
    check_mode("R2 contiguous after gap", 1);
  endtask

  task automatic t_clear_stream();
    do_clear();
    for (int i = 0; i < 9; i++) do_write(32'h2000 + 32'(i) * 64, 8'd64, 26'd0);
    check_mode("R4 reach no-allocate", 2);
    do_clear();
    do_write(32'h2240, 8'd100, 26'd0);
    check_mode("R1 clear discards count", 0);
    do_write(32'h22A4, 8'd29, 26'd0);
    check_mode("R1 restart from size", 1);
  endtask

  task automatic t_delay();
    logic r;
    do_clear();
    do_write(32'h100, 8'd16, 26'd3);
    do_query(26'd3, r);
    check("R8 non-contiguous no hold", r, 0);
    do_write(32'h110, 8'd16, 26'd3);
    for (int i = 0; i < 5; i++) begin
      do_query(26'd3, r);
      check("R7 hold countdown", r, (i < 4) ? 1 : 0);
    end
    do_write(32'h120, 8'd16, 26'd11);
    do_query(26'd4, r);
    check("R9 other entry untouched", r, 0);
    do_query(26'd3, r);
    check("R9 aliased entry armed", r, 1);
    do_write(32'h500, 8'd16, 26'd11);
    do_query(26'd3, r);
    check("R8 non-contiguous clears entry", r, 0);
  endtask

  task automatic t_sat();
    do_clear();
    do_write(32'h0, 8'd30, 26'd0);
    check("R10 first write", mode_s, 0);
    do_write(32'd30, 8'd30, 26'd0);
    check("R10 coalesce", mode_s, 1);
    do_write(32'd60, 8'd30, 26'd0);
    check("R10 saturated count", mode_s, 2);
    check("R10 flags", coalesce_s, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ramp();
    t_break();
    t_gap();
    t_clear_stream();
    t_delay();
    t_sat();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule